// File: doc/BRIEF.md
# Slave-Select Output Controller

This block drives the chip-select lines of an SPI master toward its attached devices. Each line has an enable bit in a host-written select field. A single polarity input sets whether every line is active high or active low.

Manual mode gives the host direct control: the lines follow the select field one clock after it changes. Automatic mode hands control to the shift engine. The engine's start strobe captures the select field and drives those lines active. The engine's done strobe begins a short hold interval, and the lines fall back to inactive when that interval ends. Between transactions in automatic mode every line is inactive, whatever the select field holds. The hold interval keeps the select active past the last serial clock edge. Setup before the first edge is met by the engine, which waits at least a half serial-clock period after its start strobe.

Top module: `ssel_out_ctrl`

## Requirements
- R1: While reset is asserted with the polarity input at 0, every select line is high, which is the inactive level.
- R2: With automatic mode off, each logical line equals the matching bit of the select field sampled at the previous clock edge. Bit 0 maps to line 0 and bit 1 maps to line 1.
- R3: The polarity input acts on all lines at once and takes effect without delay. At 0, an active line is driven low. At 1, an active line is driven high.
- R4: With automatic mode on and no transaction in progress, every line is inactive, whatever the select field holds.
- R5: With automatic mode on and no transaction in progress, a start strobe sampled at a clock edge makes exactly the lines whose select bits were set at that edge active after that edge.
- R6: During an automatic transaction and its hold interval, the set of active lines does not change when the select field changes.
- R7: A done strobe sampled at clock edge d during an automatic transaction keeps the lines active after edges d through d+HOLD_CYC-1. The lines become inactive after edge d+HOLD_CYC (HOLD_CYC defaults to 2).
- R8: A done strobe with no transaction in progress has no effect. A start strobe during a transaction or its hold interval is ignored.
- R9: Turning automatic mode off ends any transaction at once. After the next edge the lines follow the select field as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | NLINES | Per-line select enable bits |
| auto_i | input | 1 | 1 = automatic mode, 0 = manual mode |
| act_high_i | input | 1 | 1 = lines active high, 0 = active low |
| start_i | input | 1 | Transaction start strobe from the shift engine |
| done_i | input | 1 | Transaction done strobe from the shift engine |
| ss_o | output | NLINES | Slave-select pins |

## Verification
A stuck busy state would leave a device selected in automatic mode after the hold interval. It would show as an active line on the cycle after edge d+HOLD_CYC. A select mask that fails to latch would let a mid-transaction change of the select field reach the pins on the very next cycle. A hold counter that is off by one moves the release edge by one cycle. For that reason the bench samples every cycle of the hold interval and the first cycle after it.

// File: rtl/ssel_out_ctrl.sv
module ssel_out_ctrl #(
  parameter int NLINES   = 2,
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] sel_i,
  input  logic              auto_i,
  input  logic              act_high_i,
  input  logic              start_i,
  input  logic              done_i,
  output logic [NLINES-1:0] ss_o
);

  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  typedef enum logic [1:0] {IDLE, RUN, HOLD} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [NLINES-1:0] mask;
  logic [NLINES-1:0] man;
  logic [NLINES-1:0] act;
  logic              busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      cnt  <= '0;
      mask <= '0;
      man  <= '0;
    end else begin
      man <= sel_i;
      if (!auto_i) begin
        st <= IDLE;
      end else begin
        case (st)
          IDLE: if (start_i) begin
            st   <= RUN;
            mask <= sel_i;
          end
          RUN: if (done_i) begin
            if (HOLD_CYC == 0) st <= IDLE;
            else begin
              st  <= HOLD;
              cnt <= CW'(HOLD_CYC - 1);
            end
          end
          HOLD: if (cnt == '0) st <= IDLE;
                else cnt <= cnt - 1'b1;
          default: st <= IDLE;
        endcase
      end
    end
  end

  assign busy = (st != IDLE);
  assign act  = auto_i ? (busy ? mask : '0) : man;
  assign ss_o = act_high_i ? act : ~act;

endmodule

module ssel_out_ctrl_chk #(
  parameter int NLINES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] sel_i,
  input logic              auto_i,
  input logic              act_high_i,
  input logic              start_i,
  input logic              busy,
  input logic [NLINES-1:0] ss_o
);
  logic [NLINES-1:0] lg;
  assign lg = act_high_i ? ss_o : ~ss_o;

  // R1
  reset_inactive_chk: assert property (@(posedge clk)
    !rst_n |-> lg == '0);

  // R2
  manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_i && $past(rst_n)) |-> lg == $past(sel_i));

  // R4
  auto_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_i && $past(auto_i) && $past(rst_n) && !$past(busy) && !$past(start_i))
      |-> lg == '0);

  // R5
  auto_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_i && $past(auto_i) && $past(rst_n) && !$past(busy) && $past(start_i))
      |-> lg == $past(sel_i));

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_i && busy && $past(busy) && $past(rst_n)) |-> $stable(lg));
endmodule

bind ssel_out_ctrl ssel_out_ctrl_chk #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .auto_i(auto_i),
  .act_high_i(act_high_i), .start_i(start_i), .busy(busy), .ss_o(ss_o)
);

// File: tb/sim_ssel_out_ctrl.sv
module sim_ssel_out_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel_i = 2'b00;
  logic       auto_i = 1'b0;
  logic       act_high_i = 1'b0;
  logic       start_i = 1'b0;
  logic       done_i = 1'b0;
  logic [1:0] ss_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ssel_out_ctrl #(.NLINES(2), .HOLD_CYC(2)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .auto_i(auto_i),
    .act_high_i(act_high_i), .start_i(start_i), .done_i(done_i), .ss_o(ss_o)
  );

  // {act_high, sel, expected pins} in manual mode
  localparam logic [4:0] VEC [8] = '{
    {1'b0, 2'b00, 2'b11}, {1'b0, 2'b01, 2'b10},
    {1'b0, 2'b10, 2'b01}, {1'b0, 2'b11, 2'b00},
    {1'b1, 2'b00, 2'b00}, {1'b1, 2'b01, 2'b01},
    {1'b1, 2'b10, 2'b10}, {1'b1, 2'b11, 2'b11}
  };

  task automatic check(input logic [1:0] exp, input string req);
    n_chk++;
    if (ss_o !== exp) begin
      n_fail++;
      $display("FAIL %s: ss_o=%b expected=%b", req, ss_o, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step();
    step();
    check(2'b11, "R1 reset level");
    rst_n = 1'b1;

    // R2, R3 manual table
    for (int i = 0; i < 8; i++) begin
      act_high_i = VEC[i][4];
      sel_i      = VEC[i][3:2];
      step();
      check(VEC[i][1:0], "R2/R3 manual vector");
    end
    // R3 polarity flips immediately
    act_high_i = 1'b0;
    #1;
    check(2'b00, "R3 polarity immediate");

    // R4 auto idle ignores select bits
    auto_i = 1'b1;
    sel_i  = 2'b11;
    step();
    check(2'b11, "R4 auto idle inactive");

    // R8 done while idle has no effect
    done_i = 1'b1;
    step();
    done_i = 1'b0;
    check(2'b11, "R8 done in idle ignored");

    // R5 start captures select field
    sel_i   = 2'b01;
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    check(2'b10, "R5 start asserts line 0");

    // R6 select change during transaction
    sel_i = 2'b10;
    step();
    check(2'b10, "R6 mask latched");

    // R8 start during transaction ignored
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    check(2'b10, "R8 start while busy ignored");

    // R7 hold interval of 2 cycles
    done_i = 1'b1;
    step();
    done_i = 1'b0;
    check(2'b10, "R7 hold cycle 1");
    step();
    check(2'b10, "R7 hold cycle 2");
    step();
    check(2'b11, "R7 released");

    // R5 with active-high polarity, both lines
    act_high_i = 1'b1;
    sel_i      = 2'b11;
    start_i    = 1'b1;
    step();
    start_i = 1'b0;
    check(2'b11, "R5 active high both lines");

    // R9 leaving auto mid-transaction
    sel_i  = 2'b10;
    auto_i = 1'b0;
    step();
    check(2'b10, "R9 manual after auto off");
    sel_i = 2'b00;
    step();
    check(2'b00, "R9 manual follows");

    // R4 back to auto: no stale transaction
    auto_i = 1'b1;
    sel_i  = 2'b11;
    step();
    check(2'b00, "R4 no stale transaction");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule